// File: doc/BRIEF.md
# Debug Test Access Port

This block is a serial test access port that gives an external scan driver access to an on-chip bus access engine. It runs entirely on the test clock `tck`. A sixteen-state controller follows the `tms` input. A 6-bit instruction register selects one of four data registers: the identification register, the one-bit bypass register, a 35-bit access command register and a 33-bit data register. All registers shift least significant bit first. `tdi` is sampled on the rising edge of `tck`, and `tdo` changes on the falling edge.

A DR scan ends in Update-DR. When the command register is selected there, the block presents the 35-bit value on `cmd_value` and pulses `cmd_update`. When the data register is selected there, it presents the 33-bit value on `data_value` and pulses `data_update`. Bit 32 of the data word is the burst-continue flag, and it is passed through unchanged. A Capture-DR of the data register loads the engine's last read word from `rd_word`.

Controller states and transitions (TMS=1 / TMS=0):

| State | TMS=1 | TMS=0 |
|---|---|---|
| TLR (Test-Logic-Reset) | TLR | RTI |
| RTI (Run-Test/Idle) | SEL_DR | RTI |
| SEL_DR | SEL_IR | CAP_DR |
| CAP_DR | EX1_DR | SH_DR |
| SH_DR | EX1_DR | SH_DR |
| EX1_DR | UPD_DR | PAU_DR |
| PAU_DR | EX2_DR | PAU_DR |
| EX2_DR | UPD_DR | SH_DR |
| UPD_DR | SEL_DR | RTI |
| SEL_IR | TLR | CAP_IR |
| CAP_IR | EX1_IR | SH_IR |
| SH_IR | EX1_IR | SH_IR |
| EX1_IR | UPD_IR | PAU_IR |
| PAU_IR | EX2_IR | PAU_IR |
| EX2_IR | UPD_IR | SH_IR |
| UPD_IR | SEL_DR | RTI |

Top module: `jtag_dbg_tap`

## Requirements
- R1: Five consecutive `tck` rising edges with `tms` high bring the controller to TLR from any state. One further edge with `tms` low moves it to RTI.
- R2: While `trst_n` is low, the block is held in reset asynchronously. In that state `tdo`, `cmd_update` and `data_update` are 0 and the instruction becomes IDCODE (code 1).
- R3: With IDCODE selected, a 32-bit DR scan shifts out `ID_VALUE` with bit 0 first.
- R4: The instruction register is 6 bits wide. Capture-IR loads 6'b000001, which is shifted out bit 0 first. The value shifted in is applied at Update-IR.
- R5: Code 63 selects the 1-bit bypass register, and so does every code other than 1, 2 and 3. The bypass register captures 0, so DR output bit i equals input bit i-1.
- R6: Code 2 selects the 35-bit command register. After an Update-DR, `cmd_value` holds the 35 bits shifted in (first bit = bit 0), and `cmd_update` is high for exactly the one `tck` cycle that follows the Update-DR edge.
- R7: Code 3 selects the 33-bit data register. After an Update-DR, `data_value` holds the 33 bits shifted in, including bit 32 (burst-continue), and `data_update` is high for exactly one cycle.
- R8: A Capture-DR with the data register selected loads `rd_word` into bits 31:0 and 0 into bit 32.
- R9: `tdo` changes only on the falling edge of `tck`. It is 0 whenever the controller is outside SH_DR and SH_IR.
- R10: A Capture-DR with the command register selected loads the last updated `cmd_value`.
- R11: A scan that passes through PAU_DR and EX2_DR back into SH_DR loses no bits and duplicates none.
- R12: IR scans and DR scans of the identification or bypass register raise no strobe, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| rd_word | input | 32 | Last read result from the bus access engine |
| cmd_update | output | 1 | One-cycle strobe: new command value |
| cmd_value | output | 35 | Command register parallel value |
| data_update | output | 1 | One-cycle strobe: new data value |
| data_value | output | 33 | Data register parallel value |

## Verification
The bench builds the block with its default parameters: a 6-bit instruction register, the 35-bit command register, the 33-bit data register and a fixed 32-bit identification code. This makes every register length reachable with a single shared shift path. Scans of 1, 6, 32, 33 and 35 bits exercise each length. A paused DR scan reaches PAU_DR and EX2_DR. The TMS-only reset is entered from the middle of a DR shift after a non-default instruction has been loaded, so it shows up as the IDCODE selection coming back.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PICK_BYP,
        PICK_ID,
        PICK_CMD,
        PICK_DAT
    } dr_pick_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr
);

    tap_state_e nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TLR;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TLR:    nxt = tms ? TLR    : RTI;
            RTI:    nxt = tms ? SEL_DR : RTI;
            SEL_DR: nxt = tms ? SEL_IR : CAP_DR;
            CAP_DR: nxt = tms ? EX1_DR : SH_DR;
            SH_DR:  nxt = tms ? EX1_DR : SH_DR;
            EX1_DR: nxt = tms ? UPD_DR : PAU_DR;
            PAU_DR: nxt = tms ? EX2_DR : PAU_DR;
            EX2_DR: nxt = tms ? UPD_DR : SH_DR;
            UPD_DR: nxt = tms ? SEL_DR : RTI;
            SEL_IR: nxt = tms ? TLR    : CAP_IR;
            CAP_IR: nxt = tms ? EX1_IR : SH_IR;
            SH_IR:  nxt = tms ? EX1_IR : SH_IR;
            EX1_IR: nxt = tms ? UPD_IR : PAU_IR;
            PAU_IR: nxt = tms ? EX2_IR : PAU_IR;
            EX2_IR: nxt = tms ? UPD_IR : SH_IR;
            UPD_IR: nxt = tms ? SEL_DR : RTI;
            default: nxt = TLR;
        endcase
    end

    // Decoded actions, valid for the rising edge that leaves the state
    always_comb begin
        in_reset = (state == TLR);
        cap_ir   = (state == CAP_IR);
        sh_ir    = (state == SH_IR);
        upd_ir   = (state == UPD_IR);
        cap_dr   = (state == CAP_DR);
        sh_dr    = (state == SH_DR);
        upd_dr   = (state == UPD_DR);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
#(
    parameter int IR_W   = 6,
    parameter int OP_ID  = 1,
    parameter int OP_CMD = 2,
    parameter int OP_DAT = 3
) (
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  logic     in_reset,
    input  logic     cap_ir,
    input  logic     sh_ir,
    input  logic     upd_ir,
    output logic     ir_lsb,
    output dr_pick_e pick
);

    localparam logic [IR_W-1:0] CAP_PATTERN = IR_W'(1);
    localparam logic [IR_W-1:0] ID_CODE     = IR_W'(OP_ID);
    localparam logic [IR_W-1:0] CMD_CODE    = IR_W'(OP_CMD);
    localparam logic [IR_W-1:0] DAT_CODE    = IR_W'(OP_DAT);

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= '0;
            ir_q  <= ID_CODE;
        end else if (in_reset) begin
            ir_q  <= ID_CODE;
        end else if (cap_ir) begin
            ir_sr <= CAP_PATTERN;
        end else if (sh_ir) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end else if (upd_ir) begin
            ir_q  <= ir_sr;
        end
    end

    always_comb begin
        if      (ir_q == ID_CODE)  pick = PICK_ID;
        else if (ir_q == CMD_CODE) pick = PICK_CMD;
        else if (ir_q == DAT_CODE) pick = PICK_DAT;
        else                       pick = PICK_BYP;
    end

    assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          CMD_W    = 35,
    parameter int          DAT_W    = 33,
    parameter logic [31:0] ID_VALUE = 32'h2C0D_E0B3
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  logic             cap_dr,
    input  logic             sh_dr,
    input  logic             upd_dr,
    input  dr_pick_e         pick,
    input  logic [DAT_W-2:0] rd_word,
    output logic             dr_lsb,
    output logic             cmd_update,
    output logic [CMD_W-1:0] cmd_value,
    output logic             data_update,
    output logic [DAT_W-1:0] data_value
);

    localparam int ID_W   = 32;
    localparam int BIG_W  = (CMD_W > DAT_W) ? CMD_W : DAT_W;
    localparam int SR_W   = (BIG_W > ID_W) ? BIG_W : ID_W;
    localparam int IDX_W  = $clog2(SR_W);

    logic [SR_W-1:0]  sr;
    logic [SR_W-1:0]  sr_shift;
    logic [IDX_W-1:0] top;

    // Index of the bit that receives tdi for the selected register
    always_comb begin
        unique case (pick)
            PICK_BYP: top = '0;
            PICK_ID:  top = IDX_W'(ID_W - 1);
            PICK_CMD: top = IDX_W'(CMD_W - 1);
            PICK_DAT: top = IDX_W'(DAT_W - 1);
            default:  top = '0;
        endcase
    end

    // One shared shift path; bits above the selected length stay zero
    always_comb begin
        for (int i = 0; i < SR_W - 1; i++) begin
            if (IDX_W'(i) == top)     sr_shift[i] = tdi;
            else if (IDX_W'(i) < top) sr_shift[i] = sr[i+1];
            else                      sr_shift[i] = 1'b0;
        end
        sr_shift[SR_W-1] = (top == IDX_W'(SR_W - 1)) ? tdi : 1'b0;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr <= '0;
        end else if (cap_dr) begin
            unique case (pick)
                PICK_BYP: sr <= '0;
                PICK_ID:  sr <= SR_W'(ID_VALUE);
                PICK_CMD: sr <= SR_W'(cmd_value);
                PICK_DAT: sr <= SR_W'({1'b0, rd_word});
                default:  sr <= '0;
            endcase
        end else if (sh_dr) begin
            sr <= sr_shift;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            cmd_update  <= 1'b0;
            data_update <= 1'b0;
            cmd_value   <= '0;
            data_value  <= '0;
        end else begin
            cmd_update  <= upd_dr && (pick == PICK_CMD);
            data_update <= upd_dr && (pick == PICK_DAT);
            if (upd_dr && (pick == PICK_CMD)) cmd_value  <= sr[CMD_W-1:0];
            if (upd_dr && (pick == PICK_DAT)) data_value <= sr[DAT_W-1:0];
        end
    end

    assign dr_lsb = sr[0];

endmodule

// File: rtl/jtag_dbg_tap.sv
module jtag_dbg_tap
    import tap_pkg::*;
#(
    parameter int          IR_W     = 6,
    parameter int          CMD_W    = 35,
    parameter int          DAT_W    = 33,
    parameter int          OP_ID    = 1,
    parameter int          OP_CMD   = 2,
    parameter int          OP_DAT   = 3,
    parameter logic [31:0] ID_VALUE = 32'h2C0D_E0B3
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    input  logic [DAT_W-2:0] rd_word,
    output logic             cmd_update,
    output logic [CMD_W-1:0] cmd_value,
    output logic             data_update,
    output logic [DAT_W-1:0] data_value
);

    tap_state_e state;
    dr_pick_e   pick;
    logic in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
    logic ir_lsb, dr_lsb;

    tap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .state    (state),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir),
        .cap_dr   (cap_dr),
        .sh_dr    (sh_dr),
        .upd_dr   (upd_dr)
    );

    tap_ir #(
        .IR_W   (IR_W),
        .OP_ID  (OP_ID),
        .OP_CMD (OP_CMD),
        .OP_DAT (OP_DAT)
    ) u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir),
        .ir_lsb   (ir_lsb),
        .pick     (pick)
    );

    tap_dr #(
        .CMD_W    (CMD_W),
        .DAT_W    (DAT_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck         (tck),
        .trst_n      (trst_n),
        .tdi         (tdi),
        .cap_dr      (cap_dr),
        .sh_dr       (sh_dr),
        .upd_dr      (upd_dr),
        .pick        (pick),
        .rd_word     (rd_word),
        .dr_lsb      (dr_lsb),
        .cmd_update  (cmd_update),
        .cmd_value   (cmd_value),
        .data_update (data_update),
        .data_value  (data_value)
    );

    // Output stage on the falling edge so the driver samples a settled bit
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)    tdo <= 1'b0;
        else if (sh_ir) tdo <= ir_lsb;
        else if (sh_dr) tdo <= dr_lsb;
        else            tdo <= 1'b0;
    end

endmodule

// File: rtl/tap_chk.sv
module tap_chk
    import tap_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input logic       tdo,
    input logic       cmd_update,
    input logic       data_update,
    input tap_state_e st
);

    logic [2:0] ones_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              ones_run <= '0;
        else if (!tms)            ones_run <= '0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> (st == TLR));

    p_cmd_pulse_r6: assert property (@(posedge tck) disable iff (!trst_n)
        cmd_update |=> !cmd_update);

    p_cmd_origin_r6: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(cmd_update) |-> $past(st == UPD_DR));

    p_dat_pulse_r7: assert property (@(posedge tck) disable iff (!trst_n)
        data_update |=> !data_update);

    p_dat_origin_r7: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(data_update) |-> $past(st == UPD_DR));

    p_tdo_quiet_r9: assert property (@(posedge tck) disable iff (!trst_n)
        !((st == SH_DR) || (st == SH_IR)) |-> !tdo);

    p_one_strobe_r12: assert property (@(posedge tck) disable iff (!trst_n)
        !(cmd_update && data_update));

endmodule

bind jtag_dbg_tap tap_chk u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .tdo         (tdo),
    .cmd_update  (cmd_update),
    .data_update (data_update),
    .st          (state)
);

// File: tb/tb_jtag_dbg_tap.sv
module tb_jtag_dbg_tap;

    localparam int          TCK_PERIOD = 20;
    localparam int          HALF       = TCK_PERIOD / 2;
    localparam logic [31:0] ID_VAL     = 32'h2C0D_E0B3;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [31:0] rd_word = '0;
    logic        cmd_update;
    logic [34:0] cmd_value;
    logic        data_update;
    logic [32:0] data_value;

    int total = 0;
    int bad   = 0;
    logic pause_quiet;

    jtag_dbg_tap dut (
        .tck         (tck),
        .trst_n      (trst_n),
        .tms         (tms),
        .tdi         (tdi),
        .tdo         (tdo),
        .rd_word     (rd_word),
        .cmd_update  (cmd_update),
        .cmd_value   (cmd_value),
        .data_update (data_update),
        .data_value  (data_value)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One TCK cycle: inputs set while low, tdo sampled just before the rise
    task automatic step(input logic m, input logic d, output logic o);
        tms = m;
        tdi = d;
        #(HALF);
        o = tdo;
        tck = 1'b1;
        #(HALF);
        tck = 1'b0;
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
    endtask

    // Scan from RTI back to RTI; pause_at >= 0 detours through PAU_DR after that bit
    task automatic scan(input logic is_ir, input int len, input logic [63:0] din,
                        input int pause_at, output logic [63:0] dout);
        logic o;
        dout = '0;
        pause_quiet = 1'b1;
        step(1'b1, 1'b0, o);
        if (is_ir) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < len; i++) begin
            step((i == len - 1) || (i == pause_at), din[i], o);
            dout[i] = o;
            if (i == pause_at && i != len - 1) begin
                step(1'b0, 1'b0, o);
                step(1'b0, 1'b0, o);
                if (o !== 1'b0) pause_quiet = 1'b0;
                step(1'b1, 1'b0, o);
                step(1'b0, 1'b0, o);
            end
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic load_ir(input logic [5:0] code);
        logic [63:0] d;
        scan(1'b1, 6, 64'(code), -1, d);
    endtask

    task automatic t_reset;
        check(tdo === 1'b0, "R2 tdo in reset", 64'(tdo), 0);
        check(cmd_update === 1'b0 && data_update === 1'b0, "R2 strobes in reset",
              64'({cmd_update, data_update}), 0);
        trst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_idcode;
        logic [63:0] d;
        scan(1'b0, 32, 64'h0, -1, d);
        check(d[31:0] === ID_VAL, "R3 idcode after reset", d, 64'(ID_VAL));
        check(!cmd_update && !data_update, "R12 no strobe on idcode scan",
              64'({cmd_update, data_update}), 0);
    endtask

    task automatic t_ir_capture;
        logic [63:0] d;
        scan(1'b1, 6, 64'd63, -1, d);
        check(d[5:0] === 6'b000001, "R4 ir capture pattern", d, 64'h1);
        check(!cmd_update && !data_update, "R12 no strobe on ir scan",
              64'({cmd_update, data_update}), 0);
    endtask

    task automatic t_bypass(input logic [5:0] code, input string tag);
        logic [63:0] d;
        logic [63:0] din = 64'h0000_0000_A5C3_96F1;
        load_ir(code);
        scan(1'b0, 32, din, -1, d);
        check(d[31:0] === {din[30:0], 1'b0}, tag, d, 64'({din[30:0], 1'b0}));
    endtask

    task automatic t_cmd;
        logic [63:0] d;
        logic [34:0] v1 = 35'h5_9000_0020;
        logic [34:0] v2 = 35'h2_1234_5678;
        logic o;
        load_ir(6'd2);
        scan(1'b0, 35, 64'(v1), -1, d);
        check(cmd_update === 1'b1, "R6 cmd strobe high", 64'(cmd_update), 1);
        check(cmd_value === v1, "R6 cmd value", 64'(cmd_value), 64'(v1));
        check(data_update === 1'b0, "R12 no data strobe on cmd", 64'(data_update), 0);
        step(1'b0, 1'b0, o);
        check(cmd_update === 1'b0, "R6 cmd strobe one cycle", 64'(cmd_update), 0);
        scan(1'b0, 35, 64'(v2), -1, d);
        check(d[34:0] === v1, "R10 cmd capture readback", d, 64'(v1));
        check(cmd_value === v2, "R6 cmd value second", 64'(cmd_value), 64'(v2));
    endtask

    task automatic t_data;
        logic [63:0] d;
        logic [32:0] w = 33'h1_0000_0010;
        logic o;
        load_ir(6'd3);
        rd_word = 32'hDEAD_BEEF;
        scan(1'b0, 33, 64'(w), -1, d);
        check(d[32:0] === {1'b0, 32'hDEAD_BEEF}, "R8 data capture", d, 64'h0DEAD_BEEF);
        check(data_update === 1'b1, "R7 data strobe high", 64'(data_update), 1);
        check(data_value === w, "R7 data value with burst bit", 64'(data_value), 64'(w));
        check(cmd_update === 1'b0, "R12 no cmd strobe on data", 64'(cmd_update), 0);
        step(1'b0, 1'b0, o);
        check(data_update === 1'b0, "R7 data strobe one cycle", 64'(data_update), 0);
    endtask

    task automatic t_pause;
        logic [63:0] d;
        logic [32:0] w = 33'h0_8765_4321;
        rd_word = 32'h0F1E_2D3C;
        scan(1'b0, 33, 64'(w), 13, d);
        check(data_value === w, "R11 paused shift in", 64'(data_value), 64'(w));
        check(d[32:0] === {1'b0, 32'h0F1E_2D3C}, "R11 paused shift out", d,
              64'h0_0F1E_2D3C);
        check(pause_quiet === 1'b1, "R9 tdo low in pause", 64'(pause_quiet), 1);
    endtask

    task automatic t_tms_reset;
        logic [63:0] d;
        logic o;
        load_ir(6'd63);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b1, o);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        scan(1'b0, 32, 64'h0, -1, d);
        check(d[31:0] === ID_VAL, "R1 tms reset restores idcode", d, 64'(ID_VAL));
    endtask

    task automatic t_async_reset;
        logic [63:0] d;
        load_ir(6'd3);
        trst_n = 1'b0;
        #(HALF);
        check(tdo === 1'b0, "R2 tdo after async reset", 64'(tdo), 0);
        trst_n = 1'b1;
        idle(1);
        scan(1'b0, 32, 64'h0, -1, d);
        check(d[31:0] === ID_VAL, "R2 idcode after async reset", d, 64'(ID_VAL));
    endtask

    initial begin
        #(TCK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(TCK_PERIOD);
        t_reset();
        t_idcode();
        t_ir_capture();
        t_bypass(6'd63, "R5 bypass code 63");
        t_bypass(6'd5, "R5 bypass unassigned code");
        t_cmd();
        t_data();
        t_pause();
        t_tms_reset();
        t_async_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule